// File: doc/BRIEF.md
# Dot-Clock Source Selector with Post-Divider

This block picks one of eight dot-clock sources and produces a pixel-clock enable from it, all inside a single fast system clock domain. Each source is represented by a tick enable that pulses once per period of that source's rate. Software selects a source with a three-bit index. The low two bits come from a two-bit clock-select field in the miscellaneous output register. The top bit comes from one bit of an extended graphics register. Indices 0 and 1 are the two standard VGA dot clocks. Indices 2 to 7 stand for 36, 65.1, 44.9, 50, 80 and 75 MHz sources.

A two-bit divider code then thins the selected tick stream by 1, 1.5, 2 or 4. The divide-by-1.5 setting keeps two ticks out of every three. The block registers the active index and code and drives them out as status, so that display timing can be recomputed from them. After any change of index or code, the divider restarts its phase on the first tick of the new setting. This keeps a stale phase from cutting short the first output period.

Top module: `pixclk_sel_div`

## Requirements
- R1: `src_idx` equals `{ext_clk_sel, misc_clk_sel}` as sampled on the previous clock edge. It is 0 during and after reset.
- R2: Only `src_tick[src_idx]` advances the divider. Ticks on any other line have no effect on `pix_en`.
- R3: With divider code 0, every selected tick produces a one-cycle `pix_en` pulse on the clock after the tick.
- R4: With divider code 1, the selected ticks are counted from phase 0 after a restart. Ticks at phase 1 and phase 2 of each group of three produce a pulse, and phase 0 does not. This gives 2 pulses per 3 ticks, with gaps of 1 and 2 ticks that alternate.
- R5: With divider code 2, every second selected tick after a restart produces a pulse, starting with the second tick.
- R6: With divider code 3, every fourth selected tick after a restart produces a pulse, starting with the fourth tick.
- R7: A change of the source index or the divider code makes the next selected tick count as phase 0 of the new setting, whatever phase the divider had reached.
- R8: `div_sel` equals `div_code` as sampled on the previous clock edge. It is 0 during and after reset, and `pix_en` is 0 in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_tick | input | 8 | One tick enable per dot-clock source |
| misc_clk_sel | input | 2 | Clock-select field from the miscellaneous output register |
| ext_clk_sel | input | 1 | Extended clock-select bit, the top bit of the index |
| div_code | input | 2 | Post-divider code: 0 gives /1, 1 gives /1.5, 2 gives /2, 3 gives /4 |
| pix_en | output | 1 | Pixel-clock enable pulse |
| src_idx | output | 3 | Registered active source index |
| div_sel | output | 2 | Registered active divider code |

## Verification
Each divider code is run over a twelve-tick window. The bench compares every tick's pulse or no-pulse against an expected phase sequence and also checks the total count. This separates /1.5 from /2 and proves that the 1.5 gaps alternate. Tick spacing changes between windows: back-to-back ticks, and ticks with idle cycles between them. This shows that the output follows ticks rather than the system clock. Ticks on unselected lines check that they are ignored. A change of code or source in mid-phase shows whether the phase restarts: a stale count would produce an early or a late first pulse.

// File: rtl/pixclk_sel_div.sv
module pixclk_sel_div (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] src_tick,
  input  logic [1:0] misc_clk_sel,
  input  logic       ext_clk_sel,
  input  logic [1:0] div_code,
  output logic       pix_en,
  output logic [2:0] src_idx,
  output logic [1:0] div_sel
);

  logic [2:0] idx_in;
  logic       pend;
  logic [1:0] phase;
  logic [1:0] last;
  logic [1:0] ph_now;
  logic       tick;
  logic       fire;

  assign idx_in = {ext_clk_sel, misc_clk_sel};
  assign tick   = src_tick[src_idx];
  assign ph_now = pend ? 2'd0 : phase;

  always_comb begin
    case (div_sel)
      2'd0:    last = 2'd0;
      2'd1:    last = 2'd2;
      2'd2:    last = 2'd1;
      default: last = 2'd3;
    endcase
  end

  assign fire = (div_sel == 2'd1) ? (ph_now != 2'd0) : (ph_now == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_idx <= 3'd0;
      div_sel <= 2'd0;
      pend    <= 1'b0;
      phase   <= 2'd0;
      pix_en  <= 1'b0;
    end else begin
      src_idx <= idx_in;
      div_sel <= div_code;
      pix_en  <= tick & fire;
      if (tick)
        phase <= (ph_now == last) ? 2'd0 : ph_now + 2'd1;
      if ((idx_in != src_idx) || (div_code != div_sel))
        pend <= 1'b1;
      else if (tick)
        pend <= 1'b0;
    end
  end

endmodule

module pixclk_sel_div_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] src_tick,
  input logic [1:0] misc_clk_sel,
  input logic       ext_clk_sel,
  input logic [1:0] div_code,
  input logic       pix_en,
  input logic [2:0] src_idx,
  input logic [1:0] div_sel
);

  AST_IDX_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> src_idx == $past({ext_clk_sel, misc_clk_sel})); // R1

  AST_DIV_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> div_sel == $past(div_code)); // R8

  AST_PIX_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |-> $past(src_tick[src_idx])); // R2

  AST_DIV1_EVERY_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    src_tick[src_idx] && div_sel == 2'd0 |=> pix_en); // R3

  AST_DIV2_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en && div_sel == 2'd2 && div_code == 2'd2 |=> !pix_en); // R5

endmodule

bind pixclk_sel_div pixclk_sel_div_chk u_chk (.*);

// File: tb/pixclk_sel_div_bench.sv
module pixclk_sel_div_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_tick = 8'd0;
  logic [1:0] misc_clk_sel = 2'd0;
  logic       ext_clk_sel = 1'b0;
  logic [1:0] div_code = 2'd0;
  logic       pix_en;
  logic [2:0] src_idx;
  logic [1:0] div_sel;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  int cur_idx = 0;
  int cur_code = 0;
  int bphase = 0;
  bit exp_q[$];
  string tag_q[$];
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pixclk_sel_div u_pixclk_sel_div (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit t;
    t = |src_tick;
    #2;
    if (pix_en) pulses++;
    if (t) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 queue empty", pix_en, 0);
      else begin
        bit e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        chk(pix_en == e, tg, pix_en, e);
      end
    end
  end

  function automatic bit model_fire(input int code, input int p);
    case (code)
      0: return 1'b1;
      1: return p != 0;
      2: return p == 1;
      default: return p == 3;
    endcase
  endfunction

  function automatic int model_mod(input int code);
    case (code)
      0: return 1;
      1: return 3;
      2: return 2;
      default: return 4;
    endcase
  endfunction

  task automatic set_cfg(input int idx, input int code);
    @(negedge clk);
    ext_clk_sel = idx[2];
    misc_clk_sel = idx[1:0];
    div_code = code[1:0];
    cur_idx = idx;
    cur_code = code;
    bphase = 0;
    @(negedge clk);
    @(negedge clk);
    chk(src_idx == idx[2:0], "R1 src_idx", src_idx, idx);
    chk(div_sel == code[1:0], "R8 div_sel", div_sel, code);
  endtask

  task automatic tick(input int line, input int gap, input string tag);
    @(negedge clk);
    src_tick = 8'd1 << line;
    if (line == cur_idx) begin
      exp_q.push_back(model_fire(cur_code, bphase));
      bphase = (bphase + 1) % model_mod(cur_code);
    end else exp_q.push_back(1'b0);
    tag_q.push_back(tag);
    if (gap > 0) begin
      @(negedge clk);
      src_tick = 8'd0;
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    src_tick = 8'd0;
    repeat (3) @(negedge clk);
  endtask

  task automatic window(input int idx, input int code, input int gap, input int expn, input string tag);
    set_cfg(idx, code);
    pulses = 0;
    for (int i = 0; i < 12; i++) tick(idx, gap, tag);
    idle();
    chk(pulses == expn, {tag, " window count"}, pulses, expn);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pix_en == 1'b0, "R8 reset pix_en", pix_en, 0);
    chk(src_idx == 3'd0, "R1 reset src_idx", src_idx, 0);
    chk(div_sel == 2'd0, "R8 reset div_sel", div_sel, 0);
    rst_n = 1'b1;
    window(0, 0, 2, 12, "R3 div1");
    window(3, 1, 0, 8, "R4 div1.5");
    window(5, 2, 3, 6, "R5 div2");
    window(7, 3, 1, 3, "R6 div4");
    window(4, 1, 2, 8, "R4 div1.5 spaced");
    set_cfg(2, 0);
    tick(4, 1, "R2 unselected line");
    tick(6, 1, "R2 unselected line");
    tick(2, 1, "R2 selected line");
    tick(3, 0, "R2 unselected line");
    idle();
    set_cfg(6, 3);
    tick(6, 1, "R7 pre");
    tick(6, 1, "R7 pre");
    set_cfg(6, 2);
    for (int i = 0; i < 4; i++) tick(6, 1, "R7 code change");
    tick(6, 1, "R7 pre");
    set_cfg(1, 2);
    for (int i = 0; i < 2; i++) tick(1, 1, "R7 source change");
    set_cfg(1, 3);
    tick(1, 1, "R7 pre");
    set_cfg(5, 3);
    for (int i = 0; i < 4; i++) tick(5, 1, "R7 source change div4");
    idle();
    chk(exp_q.size() == 0, "R2 leftover items", exp_q.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule